// File: doc/BRIEF.md
# Video Field DMA Address Generator

This block produces the memory addresses for one video DMA channel that moves a field line by line. A field-start strobe, together with an odd/even flag, picks one of two base addresses. The block then steps one dword at a time through the bytes of the current line. At the end of the line it moves the line start by a programmable signed pitch. The pitch is added normally and subtracted when the field is stored bottom-up. Each dword on the data path passes through a selectable byte swap.

A direction bit sets the mode. In read mode (the bit is 1) the line and byte counts set the size of the field, and the walk ends on its own after the last dword. In write mode (the bit is 0) the counts act as a crop window. Dwords beyond the per-line quota are refused until the source marks a new line with the line-sync strobe. Lines beyond the line quota are refused until the next field starts. A protection bound stops the channel with a sticky violation flag. A programmable range size raises a one-cycle interrupt each time the transfer address moves into a new range-sized region.

Top module: `vfield_addr_gen`

## Requirements
- R1: After reset `xfer_ok`, `viol` and `irq` are 0. No dword is accepted until the first `field_start`.
- R2: On `field_start` the first address equals `base_odd` when `field_odd` is 1 and `base_even` when it is 0.
- R3: Within a line, each accepted dword advances `addr` by 4. A line holds `bytes_m1[11:2]+1` dwords, because `bytes_m1` is the byte count minus one.
- R4: The first address of each following line is the previous line's first address plus `pitch`. When `flip` is 1 it is the previous line's first address minus `pitch`.
- R5: In read mode (`rd_mode`=1) the walk covers `lines_m1+1` lines. After the last dword of the last line, `xfer_ok` stays 0 until the next `field_start`. In this mode `line_sync` has no effect.
- R6: In write mode (`rd_mode`=0), dwords past the line quota are refused until `line_sync`. Each `line_sync` moves to the next line start. A `line_sync` received on the last line stops the field until the next `field_start`.
- R7: `data_out` is `data_in` with byte swap code `swap`: 0 passes it through, 1 swaps the bytes inside each 16-bit half (bytes 3,2,1,0 become 2,3,0,1), 2 reverses all four bytes, and 3 passes it through.
- R8: A requested dword whose `addr[31:2]` is greater than or equal to `prot_dw` is refused. `viol` rises on the next cycle, stays 1, and blocks all transfers until the next `field_start` clears it.
- R9: With `limit` L nonzero, `irq` is 1 for exactly the cycle after an accepted dword whose address bits from L+6 upward differ from those of the previous accepted dword of the same field. With L=0, `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_mode | input | 1 | 1 reads from memory, 0 writes to memory |
| flip | input | 1 | Walk lines bottom-up |
| swap | input | 2 | Byte swap code |
| lines_m1 | input | 12 | Lines per field minus one |
| bytes_m1 | input | 12 | Bytes per line minus one |
| base_odd | input | 32 | First address of odd fields |
| base_even | input | 32 | First address of even fields |
| pitch | input | 32 | Line-to-line address distance |
| prot_dw | input | 30 | Protection bound, dword address |
| limit | input | 4 | Interrupt range code, size 2^(limit+6) bytes |
| field_start | input | 1 | Start of a field |
| field_odd | input | 1 | Field parity at field_start |
| line_sync | input | 1 | New incoming line, write mode |
| xfer_req | input | 1 | A dword is offered for transfer |
| data_in | input | 32 | Dword entering the channel |
| xfer_ok | output | 1 | Offered dword is accepted at addr |
| addr | output | 32 | Address of the current dword |
| data_out | output | 32 | Swapped dword |
| viol | output | 1 | Sticky protection violation |
| irq | output | 1 | Range boundary interrupt pulse |

## Verification
The bench checks the dword at the end of a line, where a wrong N-1 decode gives one dword too many or too few, and the line after the last one, where a missing stop lets addresses run past the field. In flip mode a design that always adds the pitch would walk upward instead of downward. In write mode, the dword just past the quota and the `line_sync` on the last line show whether cropping lets extra data in. The dword that exactly reaches the protection bound and the dword that crosses a 128-byte boundary would expose an off-by-one compare or a missing first-dword guard.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

    typedef enum logic [1:0] {
        SWP_NONE = 2'd0,
        SWP_HALF = 2'd1,
        SWP_FULL = 2'd2,
        SWP_RSVD = 2'd3
    } swap_e;

    localparam int unsigned RANGE_BASE_SHIFT = 6;
    localparam int unsigned DWORD_BYTES      = 4;

    function automatic logic [31:0] swap_dword(input logic [31:0] d, input swap_e code);
        logic [31:0] r;
        case (code)
            SWP_HALF: r = {d[23:16], d[31:24], d[7:0], d[15:8]};
            SWP_FULL: r = {d[7:0], d[15:8], d[23:16], d[31:24]};
            default:  r = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vfd_line_walker.sv
module vfd_line_walker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_base,
    input  logic              take,
    input  logic              line_sync,
    input  logic              rd_mode,
    input  logic              flip,
    input  logic [ADDR_W-1:0] pitch,
    input  logic [CNT_W-1:0]  lines_m1,
    input  logic [CNT_W-1:0]  bytes_m1,
    output logic [ADDR_W-1:0] addr,
    output logic              ready
);
    import vfd_pkg::*;

    localparam logic [CNT_W-1:0]  STEP   = CNT_W'(DWORD_BYTES);
    localparam logic [ADDR_W-1:0] ASTEP  = ADDR_W'(DWORD_BYTES);

    logic [ADDR_W-1:0] line_base, cur;
    logic [CNT_W-1:0]  line_idx, boff;
    logic              active, crop;
    logic              last_dw, last_line, wsync;
    logic [ADDR_W-1:0] nxt_base;

    always_comb begin
        last_dw   = ({1'b0, boff} + {1'b0, STEP}) > {1'b0, bytes_m1};
        last_line = (line_idx == lines_m1);
        nxt_base  = flip ? (line_base - pitch) : (line_base + pitch);
        wsync     = !rd_mode && line_sync && active;
        ready     = active && !crop && !wsync;
        addr      = cur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_base <= '0;
            cur       <= '0;
            line_idx  <= '0;
            boff      <= '0;
            active    <= 1'b0;
            crop      <= 1'b0;
        end else if (start) begin
            line_base <= start_base;
            cur       <= start_base;
            line_idx  <= '0;
            boff      <= '0;
            active    <= 1'b1;
            crop      <= 1'b0;
        end else if (wsync) begin
            if (last_line) begin
                active <= 1'b0;
            end else begin
                line_base <= nxt_base;
                cur       <= nxt_base;
                line_idx  <= line_idx + 1'b1;
                boff      <= '0;
                crop      <= 1'b0;
            end
        end else if (take) begin
            if (last_dw) begin
                if (!rd_mode) begin
                    crop <= 1'b1;
                end else if (last_line) begin
                    active <= 1'b0;
                end else begin
                    line_base <= nxt_base;
                    cur       <= nxt_base;
                    line_idx  <= line_idx + 1'b1;
                    boff      <= '0;
                end
            end else begin
                cur  <= cur + ASTEP;
                boff <= boff + STEP;
            end
        end
    end

    AST_STEP_IN_LINE: assert property (@(posedge clk) disable iff (rst)
        (take && !last_dw && !start && !wsync) |=> (addr == $past(addr) + ASTEP)); // R3

    AST_CROP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ready && !start && !wsync && !rd_mode && $past(rd_mode)) |=> !ready || $past(start) || $past(wsync)); // R6

endmodule

// File: rtl/vfd_guard.sv
module vfd_guard #(
    parameter int ADDR_W = 32,
    parameter int LIM_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              try_xfer,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:2] prot_dw,
    input  logic [LIM_W-1:0]  limit,
    output logic              take,
    output logic              viol,
    output logic              irq
);
    import vfd_pkg::*;

    localparam int SH_W = LIM_W + 2;

    logic              hit;
    logic [SH_W-1:0]   range_sh;
    logic [ADDR_W-1:0] range_mask;
    logic [ADDR_W-1:0] last_addr;
    logic              have_last;
    logic              crossed;

    always_comb begin
        hit        = addr[ADDR_W-1:2] >= prot_dw;
        take       = try_xfer && !viol && !hit;
        range_sh   = SH_W'(limit) + SH_W'(RANGE_BASE_SHIFT);
        range_mask = {ADDR_W{1'b1}} << range_sh;
        crossed    = have_last && (((last_addr ^ addr) & range_mask) != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            viol      <= 1'b0;
            irq       <= 1'b0;
            last_addr <= '0;
            have_last <= 1'b0;
        end else if (start) begin
            viol      <= 1'b0;
            irq       <= 1'b0;
            have_last <= 1'b0;
        end else begin
            if (try_xfer && hit)
                viol <= 1'b1;
            irq <= take && (limit != '0) && crossed;
            if (take) begin
                last_addr <= addr;
                have_last <= 1'b1;
            end
        end
    end

    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (viol && !start) |=> viol); // R8

    AST_IRQ_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (rst)
        irq |-> ($past(limit) != '0)); // R9

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (irq && !$past(take)) |-> 1'b0); // R9

endmodule

// File: rtl/vfield_addr_gen.sv
module vfield_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 12,
    parameter int LIM_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_mode,
    input  logic              flip,
    input  logic [1:0]        swap,
    input  logic [CNT_W-1:0]  lines_m1,
    input  logic [CNT_W-1:0]  bytes_m1,
    input  logic [ADDR_W-1:0] base_odd,
    input  logic [ADDR_W-1:0] base_even,
    input  logic [ADDR_W-1:0] pitch,
    input  logic [ADDR_W-3:0] prot_dw,
    input  logic [LIM_W-1:0]  limit,
    input  logic              field_start,
    input  logic              field_odd,
    input  logic              line_sync,
    input  logic              xfer_req,
    input  logic [31:0]       data_in,
    output logic              xfer_ok,
    output logic [ADDR_W-1:0] addr,
    output logic [31:0]       data_out,
    output logic              viol,
    output logic              irq
);
    import vfd_pkg::*;

    logic [ADDR_W-1:0] start_base;
    logic              w_ready, try_xfer, take;

    assign start_base = field_odd ? base_odd : base_even;
    assign try_xfer   = xfer_req && w_ready && !field_start;
    assign xfer_ok    = take;
    assign data_out   = swap_dword(data_in, swap_e'(swap));

    vfd_line_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .start     (field_start),
        .start_base(start_base),
        .take      (take),
        .line_sync (line_sync),
        .rd_mode   (rd_mode),
        .flip      (flip),
        .pitch     (pitch),
        .lines_m1  (lines_m1),
        .bytes_m1  (bytes_m1),
        .addr      (addr),
        .ready     (w_ready)
    );

    vfd_guard #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_guard (
        .clk      (clk),
        .rst      (rst),
        .start    (field_start),
        .try_xfer (try_xfer),
        .addr     (addr),
        .prot_dw  (prot_dw),
        .limit    (limit),
        .take     (take),
        .viol     (viol),
        .irq      (irq)
    );

    AST_NO_XFER_AFTER_VIOL: assert property (@(posedge clk) disable iff (rst)
        viol |-> !xfer_ok); // R8

    AST_OK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        xfer_ok |-> (xfer_req && !field_start)); // R1

    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (rst)
        field_start |=> (addr == ($past(field_odd) ? $past(base_odd) : $past(base_even)))); // R2

endmodule

// File: tb/tb_vfield_addr_gen.sv
module tb_vfield_addr_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        rd_mode, flip;
    logic [1:0]  swap;
    logic [11:0] lines_m1, bytes_m1;
    logic [31:0] base_odd, base_even, pitch;
    logic [29:0] prot_dw;
    logic [3:0]  limit;
    logic        field_start, field_odd, line_sync, xfer_req;
    logic [31:0] data_in;
    logic        xfer_ok, viol, irq;
    logic [31:0] addr, data_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    vfield_addr_gen dut (
        .clk(clk), .rst(rst), .rd_mode(rd_mode), .flip(flip), .swap(swap),
        .lines_m1(lines_m1), .bytes_m1(bytes_m1), .base_odd(base_odd),
        .base_even(base_even), .pitch(pitch), .prot_dw(prot_dw), .limit(limit),
        .field_start(field_start), .field_odd(field_odd), .line_sync(line_sync),
        .xfer_req(xfer_req), .data_in(data_in), .xfer_ok(xfer_ok), .addr(addr),
        .data_out(data_out), .viol(viol), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_field(input logic odd);
        field_odd   = odd;
        field_start = 1'b1;
        @(negedge clk);
        field_start = 1'b0;
    endtask

    task automatic push(input string req, input logic exp_ok, input logic [31:0] exp_addr);
        xfer_req = 1'b1;
        #2;
        chk({req, " ok"}, {31'd0, xfer_ok}, {31'd0, exp_ok});
        if (exp_ok) chk({req, " addr"}, addr, exp_addr);
        @(negedge clk);
        xfer_req = 1'b0;
    endtask

    task automatic sync_line();
        line_sync = 1'b1;
        @(negedge clk);
        line_sync = 1'b0;
    endtask

    task automatic t_reset();
        #2;
        chk("R1 ok", {31'd0, xfer_ok}, 0);
        chk("R1 viol", {31'd0, viol}, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        push("R1 before field", 1'b0, 0);
    endtask

    task automatic t_read_walk();
        rd_mode = 1; flip = 0; bytes_m1 = 12'd11; lines_m1 = 12'd2; pitch = 32'h100;
        start_field(1'b1);
        for (int l = 0; l < 3; l++)
            for (int d = 0; d < 3; d++)
                push(l == 0 ? (d == 0 ? "R2" : "R3") : (d == 0 ? "R4" : "R3"),
                     1'b1, 32'h1000 + l * 32'h100 + d * 4);
        push("R5 past end", 1'b0, 0);
        push("R5 still stopped", 1'b0, 0);
    endtask

    task automatic t_flip_even();
        rd_mode = 1; flip = 1; bytes_m1 = 12'd3; lines_m1 = 12'd2; pitch = 32'h100;
        start_field(1'b0);
        push("R2 even base", 1'b1, 32'h8000);
        push("R4 flip line1", 1'b1, 32'h7F00);
        push("R4 flip line2", 1'b1, 32'h7E00);
        push("R5 flip end", 1'b0, 0);
        flip = 0;
    endtask

    task automatic t_read_sync_ignored();
        rd_mode = 1; bytes_m1 = 12'd11; lines_m1 = 12'd0; pitch = 32'h100;
        start_field(1'b1);
        push("R3", 1'b1, 32'h1000);
        sync_line();
        push("R5 sync ignored", 1'b1, 32'h1004);
    endtask

    task automatic t_write_crop();
        rd_mode = 0; bytes_m1 = 12'd7; lines_m1 = 12'd1; pitch = 32'h200;
        start_field(1'b1);
        push("R6 line0 d0", 1'b1, 32'h1000);
        push("R6 line0 d1", 1'b1, 32'h1004);
        push("R6 cropped byte", 1'b0, 0);
        push("R6 still cropped", 1'b0, 0);
        sync_line();
        push("R6 line1 d0", 1'b1, 32'h1200);
        sync_line();
        push("R6 cropped line", 1'b0, 0);
        sync_line();
        push("R6 still cropped line", 1'b0, 0);
        start_field(1'b0);
        push("R6 new field", 1'b1, 32'h8000);
        rd_mode = 1;
    endtask

    task automatic t_swap();
        data_in = 32'h11223344;
        swap = 2'd0; #2 chk("R7 none", data_out, 32'h11223344);
        swap = 2'd1; #2 chk("R7 half", data_out, 32'h22114433);
        swap = 2'd2; #2 chk("R7 full", data_out, 32'h44332211);
        swap = 2'd3; #2 chk("R7 reserved", data_out, 32'h11223344);
        swap = 2'd0;
        @(negedge clk);
    endtask

    task automatic t_protect();
        rd_mode = 1; bytes_m1 = 12'd15; lines_m1 = 12'd0;
        prot_dw = 30'h1008 >> 2;
        start_field(1'b1);
        push("R8 below", 1'b1, 32'h1000);
        push("R8 below", 1'b1, 32'h1004);
        chk("R8 viol low", {31'd0, viol}, 0);
        push("R8 at bound", 1'b0, 0);
        chk("R8 viol set", {31'd0, viol}, 1);
        prot_dw = 30'h3FFF_FFFF;
        push("R8 blocked", 1'b0, 0);
        chk("R8 sticky", {31'd0, viol}, 1);
        start_field(1'b1);
        chk("R8 cleared", {31'd0, viol}, 0);
        push("R8 resumes", 1'b1, 32'h1000);
    endtask

    task automatic t_irq(input logic [3:0] lim);
        rd_mode = 1; bytes_m1 = 12'd31; lines_m1 = 12'd0; limit = lim;
        base_odd = 32'h1070;
        start_field(1'b1);
        for (int d = 0; d < 8; d++) begin
            push("R9", 1'b1, 32'h1070 + d * 4);
            chk(lim == 0 ? "R9 disabled" : "R9 pulse", {31'd0, irq},
                {31'd0, (lim != 0) && (d == 4)});
        end
        base_odd = 32'h1000; limit = 0;
    endtask

    initial begin
        rst = 1; rd_mode = 1; flip = 0; swap = 0; lines_m1 = 0; bytes_m1 = 0;
        base_odd = 32'h1000; base_even = 32'h8000; pitch = 32'h100;
        prot_dw = 30'h3FFF_FFFF; limit = 0; field_start = 0; field_odd = 0;
        line_sync = 0; xfer_req = 0; data_in = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_read_walk();
        t_flip_even();
        t_read_sync_ignored();
        t_write_crop();
        t_swap();
        t_protect();
        t_irq(4'd1);
        t_irq(4'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule